// File: doc/BRIEF.md
# Serial Flash Read Responder

This block is the device end of a four-wire serial NOR flash, limited to its read path. A host lowers chip select, clocks in an 8-bit command code and a 24-bit address on the serial input, and the block then returns bytes from a small internal array. It keeps returning them for as long as the host keeps clocking. The serial pins are sampled by the block's own system clock, so the host serial clock must run several times slower than that clock. The bus is used in clock-idle-low fashion: the host samples on rising edges and the device launches on falling edges.

Two commands are recognised: a plain read, and a fast read that adds one dummy byte before the data. A busy input stands for a program or erase cycle running elsewhere in the device. A read that arrives while busy is high is refused and leaves the device quiet. The serial data output is modelled as a data bit plus an output enable.

Top module: `sflash_read_resp`

## Requirements
- R1: While reset is held, and directly after it, the output enable `so_en` is low.
- R2: Command code 0x03 followed by a 24-bit address, sent most significant bit first and sampled on rising serial clock edges, starts a read. Only the low `AW` address bits (8 by default) select the array byte. The byte at index i holds ((i*29) mod 256) XOR 0xC3.
- R3: Data bits change only after falling serial clock edges. They are sent most significant bit first, and `so_en` is high for each of them. The first data bit follows the falling edge after the last address bit.
- R4: After every full byte the array index advances by one, and bytes continue for as long as chip select stays low.
- R5: Command code 0x0B works like 0x03, but eight dummy clocks follow the address before the first data bit.
- R6: If `busy` is high when the eighth command bit is sampled, the read is refused: `so_en` stays low until chip select rises.
- R7: `so_en` is low while command, address and dummy bits are being received.
- R8: Raising chip select at any point ends the command and drops `so_en`. The next command is decoded from its first bit.
- R9: The array index wraps from the last implemented byte back to zero.
- R10: Any command code other than 0x03 and 0x0B is ignored, with `so_en` held low until chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select from the host, active low |
| sck | input | 1 | Serial clock from the host, idle low |
| si | input | 1 | Serial data from the host |
| busy | input | 1 | High while a program or erase cycle is running |
| so | output | 1 | Serial data bit towards the host |
| so_en | output | 1 | Output enable for `so`; low means high impedance |

## Verification
The hardest situations to reach are aborts that land inside a field, and the wrap of the index during a single stream. Chip select is raised after twelve address bits, and again three bits into a data byte. Each abort is followed at once by a full read, which shows that the bit counter started over. The wrap is reached by starting a stream two bytes below the top of the array and reading past it. The same driver task issues refused and unknown commands and clocks data-phase cycles after them, so that a device that wrongly drives the bus is seen at the pin.

// File: rtl/sflash_read_resp.sv
module sflash_read_resp #(
  parameter int AW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic busy,
  input  logic si,
  output logic so,
  output logic so_en
);
  localparam int DEPTH = 1 << AW;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_FAST = 8'h0B;
  localparam logic [4:0] LAST_OP = 5'd7;
  localparam logic [4:0] LAST_AD = 5'd23;

  typedef enum logic [2:0] {S_CMD, S_ADDR, S_DUMMY, S_DATA, S_SKIP} st_t;

  logic [1:0] cs_p, si_p;
  logic [2:0] sck_p;
  st_t st;
  logic [4:0] cnt;
  logic [6:0] sh;
  logic fast;
  logic [AW-1:0] addr;
  logic [2:0] bpos;
  logic [7:0] rom [DEPTH];

  always_comb
    for (int i = 0; i < DEPTH; i++) rom[i] = 8'(i * 29) ^ 8'hC3;

  wire cs_act    = ~cs_p[1];
  wire sck_rise  = sck_p[1] & ~sck_p[2];
  wire sck_fall  = ~sck_p[1] & sck_p[2];
  wire din       = si_p[1];
  wire [7:0] op  = {sh, din};
  wire streaming = (st == S_DATA);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_p  <= 2'b11;
      sck_p <= '0;
      si_p  <= '0;
    end else begin
      cs_p  <= {cs_p[0], cs_n};
      sck_p <= {sck_p[1:0], sck};
      si_p  <= {si_p[0], si};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st    <= S_CMD;
      cnt   <= '0;
      sh    <= '0;
      fast  <= 1'b0;
      addr  <= '0;
      bpos  <= '0;
      so    <= 1'b0;
      so_en <= 1'b0;
    end else if (!cs_act) begin
      st    <= S_CMD;
      cnt   <= '0;
      bpos  <= '0;
      so_en <= 1'b0;
    end else begin
      if (sck_rise)
        case (st)
          S_CMD: begin
            sh  <= op[6:0];
            cnt <= cnt + 1'b1;
            if (cnt == LAST_OP) begin
              cnt <= '0;
              if (!busy && (op == OP_READ || op == OP_FAST)) begin
                st   <= S_ADDR;
                fast <= (op == OP_FAST);
              end else
                st <= S_SKIP;
            end
          end
          S_ADDR: begin
            addr <= {addr[AW-2:0], din};
            cnt  <= cnt + 1'b1;
            if (cnt == LAST_AD) begin
              cnt  <= '0;
              bpos <= '0;
              st   <= fast ? S_DUMMY : S_DATA;
            end
          end
          S_DUMMY: begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST_OP) begin
              cnt <= '0;
              st  <= S_DATA;
            end
          end
          default: ;
        endcase
      if (sck_fall && streaming) begin
        so    <= rom[addr][3'd7 - bpos];
        so_en <= 1'b1;
        bpos  <= bpos + 1'b1;
        if (bpos == 3'd7) addr <= addr + 1'b1;
      end
    end
endmodule

// File: rtl/sflash_read_chk.sv
module sflash_read_chk #(
  parameter int AW = 8
) (
  input logic clk,
  input logic rst_n,
  input logic cs_act,
  input logic sck_fall,
  input logic streaming,
  input logic [AW-1:0] addr,
  input logic so,
  input logic so_en
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk) !rst_n |=> !so_en);

  // R8
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !so_en);

  // R3
  so_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall |=> $stable(so));

  // R7
  rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !streaming |-> !so_en);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (streaming && $past(streaming)) |->
      (addr == $past(addr) || addr == AW'($past(addr) + 1'b1)));
endmodule

bind sflash_read_resp sflash_read_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_fall(sck_fall),
  .streaming(streaming), .addr(addr), .so(so), .so_en(so_en)
);

// File: tb/sflash_read_resp_test.sv
module sflash_read_resp_test;
  localparam int HALF = 6;

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, busy = 0, si = 0;
  logic so, so_en;
  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  logic [7:0] got_byte;
  string cur_req = "R2";
  event got_ev;

  sflash_read_resp uut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
    .busy(busy), .si(si), .so(so), .so_en(so_en));

  always #2 clk = ~clk;

  function automatic logic [7:0] mem_byte(int a);
    return 8'((a % 256) * 29) ^ 8'hC3;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(got_ev) begin
    if (exp_q.size() == 0)
      check(0, cur_req, "unexpected byte", got_byte, 0);
    else begin
      logic [7:0] e;
      e = exp_q.pop_front();
      check(got_byte == e, cur_req, "data byte", got_byte, e);
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(logic [31:0] v, int n, ref int bad);
    for (int i = n - 1; i >= 0; i--) begin
      si = v[i];
      wait_clk(HALF);
      sck = 1;
      wait_clk(HALF / 2);
      if (so_en) bad++;
      wait_clk(HALF - HALF / 2);
      sck = 0;
    end
  endtask

  task automatic recv_bits(int n, output logic [7:0] b, output int en_cnt);
    b = '0;
    en_cnt = 0;
    for (int i = 0; i < n; i++) begin
      wait_clk(HALF);
      sck = 1;
      wait_clk(HALF / 2);
      b = {b[6:0], so};
      if (so_en) en_cnt++;
      wait_clk(HALF - HALF / 2);
      sck = 0;
    end
  endtask

  task automatic end_cmd(string req);
    cs_n = 1;
    wait_clk(10);
    check(!so_en, req, "so_en after chip select rise", so_en, 0);
  endtask

  task automatic read_cmd(logic [7:0] opc, logic [23:0] a, int nbytes,
                          bit accept, int tail, string req);
    int bad = 0;
    int en;
    logic [7:0] b;
    cur_req = req;
    cs_n = 0;
    wait_clk(HALF);
    send_bits({24'h0, opc}, 8, bad);
    send_bits({8'h0, a}, 24, bad);
    if (opc == 8'h0B) send_bits(32'hA5, 8, bad);
    // R7
    check(bad == 0, "R7", "so_en while receiving", bad, 0);
    if (accept)
      for (int k = 0; k < nbytes; k++) exp_q.push_back(mem_byte(int'(a) + k));
    for (int k = 0; k < nbytes; k++) begin
      recv_bits(8, b, en);
      if (accept) begin
        check(en == 8, "R3", "so_en during data byte", en, 8);
        got_byte = b;
        ->got_ev;
        wait_clk(1);
      end else
        check(en == 0, req, "so_en on refused command", en, 0);
    end
    if (tail > 0) recv_bits(tail, b, en);
  endtask

  initial begin
    wait_clk(5);
    // R1
    check(!so_en, "R1", "so_en in reset", so_en, 0);
    rst_n = 1;
    wait_clk(3);
    check(!so_en, "R1", "so_en after reset", so_en, 0);

    // R2 R4
    read_cmd(8'h03, 24'h000010, 3, 1, 0, "R2");
    end_cmd("R8");
    read_cmd(8'h03, 24'hAB3C05, 5, 1, 0, "R4");
    end_cmd("R8");
    // R5
    read_cmd(8'h0B, 24'h000020, 3, 1, 0, "R5");
    end_cmd("R8");
    // R9
    read_cmd(8'h03, 24'h0000FE, 4, 1, 0, "R9");
    end_cmd("R8");
    // R6
    busy = 1;
    read_cmd(8'h03, 24'h000030, 2, 0, 0, "R6");
    end_cmd("R6");
    read_cmd(8'h0B, 24'h000031, 1, 0, 0, "R6");
    end_cmd("R6");
    busy = 0;
    // R10
    read_cmd(8'h9F, 24'h000040, 2, 0, 0, "R10");
    end_cmd("R10");
    read_cmd(8'h02, 24'h000041, 1, 0, 0, "R10");
    end_cmd("R10");
    // R8: abort after 12 address bits
    begin
      int bad = 0;
      cur_req = "R8";
      cs_n = 0;
      wait_clk(HALF);
      send_bits(32'h03, 8, bad);
      send_bits(32'hFFF, 12, bad);
      end_cmd("R8");
    end
    read_cmd(8'h03, 24'h000044, 2, 1, 0, "R8");
    end_cmd("R8");
    // R8: abort three bits into a byte
    read_cmd(8'h03, 24'h000050, 1, 1, 3, "R8");
    end_cmd("R8");
    read_cmd(8'h0B, 24'h0000A0, 2, 1, 0, "R8");
    end_cmd("R8");

    check(exp_q.size() == 0, "R4", "bytes left unseen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "ALL", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule